// File: doc/BRIEF.md
# Keyboard Wake-Up Interrupt Controller

This block watches a row of active-low key inputs and raises a single pending condition when any of the inputs that software has turned on is pulled low. Each input has its own enable bit. The same bit also requests the pull-up device on that pin, so a pin is watched only when it is pulled up. The enabled inputs are ANDed into one signal, which a two-stage synchroniser brings into the clock domain. A falling edge on the synchronised signal sets a pending latch. The latch drives a status flag and, unless the mask is set, the interrupt request.

Software uses a small write port with two targets. Select 0 loads the enable bits. Select 1 carries the mask in bit 0, the mode in bit 1 and a one-shot acknowledge in bit 2. The acknowledge is not stored. The CPU also gives a strobe when it fetches this block's vector, and that strobe clears the latch on its own. In edge mode any clear request empties the latch. In edge-plus-level mode a clear request has no effect while any enabled input is still held low.

Top module: `keypad_irq`

## Requirements
- R1: After reset the pull-up enables are all 0, the status flag is 0 and the interrupt request is 0. Mask and mode both reset to 0, which means edge mode and unmasked.
- R2: A write with select 0 loads the enable register from the write data, and the pull-up enable output bit i equals enable bit i from the next cycle on.
- R3: When an enabled input goes low while all other enabled inputs are high, the flag is still 0 after the second rising clock edge and is 1 after the third rising clock edge following the change.
- R4: A low level or falling edge on an input whose enable bit is 0 never sets the flag.
- R5: In edge mode (control bit 1 = 0), a write with select 1 and data bit 2 = 1 clears the flag at that clock edge, even while an enabled input is still low.
- R6: In edge mode a one-cycle vector-fetch strobe clears the flag at that clock edge.
- R7: With the mask set (control bit 0 = 1) the interrupt request stays 0 and the flag still sets. With the mask clear, the request equals the flag.
- R8: In edge-plus-level mode (control bit 1 = 1), neither an acknowledge nor a vector fetch clears the flag while an enabled input is low. Once all enabled inputs are high again, an acknowledge clears it.
- R9: Setting the enable bit of an input that is already low makes a falling edge on the combined signal and sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| keyIn | input | 8 | Active-low key inputs |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 enable bits, 1 control |
| wrData | input | 8 | Write data |
| vectorFetch | input | 1 | CPU vector-fetch strobe for this block |
| pullupEn | output | 8 | Per-pin pull-up request |
| keyFlag | output | 1 | Pending status flag |
| irqReq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a clear request that arrives in edge-plus-level mode while an enabled input is still held low. The clear must not take effect, and the same latch must empty once the input is released. The stimulus table holds the key pattern low across the acknowledge or fetch and checks the flag. Cleanup then releases the keys and acknowledges again before the next vector. A directed test enables a pin that is already low, which produces an edge through the enable path rather than the pin. Another directed test measures the exact three-edge latency from pin to flag.

// File: rtl/keypad_pkg.sv
package keypad_pkg;
  typedef struct packed {
    logic ack;
    logic fetch;
    logic levelMode;
    logic mask;
  } kp_strobe_t;

  localparam int CTRL_MASK_BIT = 0;
  localparam int CTRL_MODE_BIT = 1;
  localparam int CTRL_ACK_BIT  = 2;
endpackage

// File: rtl/keypad_ctrl.sv
module keypad_ctrl
  import keypad_pkg::*;
#(
  parameter int NUM_KEYS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                wrSel,
  input  logic [NUM_KEYS-1:0] wrData,
  input  logic                vectorFetch,
  output logic [NUM_KEYS-1:0] enableQ,
  output kp_strobe_t          strobes
);
  logic maskQ;
  logic modeQ;
  logic wrCtrl;
  logic wrEnable;

  assign wrCtrl   = wrEn && wrSel;
  assign wrEnable = wrEn && !wrSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
      maskQ   <= 1'b0;
      modeQ   <= 1'b0;
    end else begin
      if (wrEnable) enableQ <= wrData;
      if (wrCtrl) begin
        maskQ <= wrData[CTRL_MASK_BIT];
        modeQ <= wrData[CTRL_MODE_BIT];
      end
    end
  end

  always_comb begin
    strobes.ack       = wrCtrl && wrData[CTRL_ACK_BIT];
    strobes.fetch     = vectorFetch;
    strobes.levelMode = modeQ;
    strobes.mask      = maskQ;
  end

  // R2: enable register follows a select-0 write
  a_r2_enable_load: assert property (@(posedge clk) disable iff (!rstN)
    wrEnable |=> (enableQ == $past(wrData)));
endmodule

// File: rtl/keypad_dp.sv
module keypad_dp
  import keypad_pkg::*;
#(
  parameter int NUM_KEYS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_KEYS-1:0] keyIn,
  input  logic [NUM_KEYS-1:0] enableQ,
  input  kp_strobe_t          strobes,
  output logic                pending,
  output logic                irqReq
);
  logic [NUM_KEYS-1:0]    gatedKeys;
  logic                   combined;
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncCur;
  logic                   syncPrev;
  logic                   fallEdge;
  logic                   heldLow;
  logic                   clearReq;

  for (genvar i = 0; i < NUM_KEYS; i++) begin : g_gate
    assign gatedKeys[i] = enableQ[i] ? keyIn[i] : 1'b1;
  end

  assign combined = &gatedKeys;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '1;
      syncPrev  <= 1'b1;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], combined};
      syncPrev  <= syncChain[SYNC_STAGES-1];
    end
  end

  assign syncCur  = syncChain[SYNC_STAGES-1];
  assign fallEdge = syncPrev && !syncCur;
  assign heldLow  = strobes.levelMode && !syncCur;
  assign clearReq = strobes.ack || strobes.fetch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (fallEdge) begin
      pending <= 1'b1;
    end else if (clearReq && !heldLow) begin
      pending <= 1'b0;
    end
  end

  assign irqReq = pending && !strobes.mask;

  // R3: a synchronised falling edge always leaves the latch set
  a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rstN)
    (syncPrev && !syncCur) |=> pending);

  // R5: edge-mode acknowledge without a new edge empties the latch
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ack && !strobes.levelMode && !(syncPrev && !syncCur)) |=> !pending);

  // R6: edge-mode vector fetch without a new edge empties the latch
  a_r6_fetch_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fetch && !strobes.levelMode && !(syncPrev && !syncCur)) |=> !pending);

  // R8: level mode keeps the latch while the combined input is low
  a_r8_level_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pending && strobes.levelMode && !syncCur) |=> pending);

  // R7: masked request never asserts
  a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
    strobes.mask |-> !irqReq);
endmodule

// File: rtl/keypad_irq.sv
module keypad_irq
  import keypad_pkg::*;
#(
  parameter int NUM_KEYS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_KEYS-1:0] keyIn,
  input  logic                wrEn,
  input  logic                wrSel,
  input  logic [NUM_KEYS-1:0] wrData,
  input  logic                vectorFetch,
  output logic [NUM_KEYS-1:0] pullupEn,
  output logic                keyFlag,
  output logic                irqReq
);
  logic [NUM_KEYS-1:0] enableQ;
  kp_strobe_t          strobes;

  keypad_ctrl #(.NUM_KEYS(NUM_KEYS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .vectorFetch(vectorFetch), .enableQ(enableQ), .strobes(strobes)
  );

  keypad_dp #(.NUM_KEYS(NUM_KEYS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .keyIn(keyIn), .enableQ(enableQ),
    .strobes(strobes), .pending(keyFlag), .irqReq(irqReq)
  );

  assign pullupEn = enableQ;
endmodule

// File: tb/sim_keypad_irq.sv
module sim_keypad_irq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 7;
  // [21:14] keys [13:6] enable [5] mode [4] mask [3:2] op(0 none,1 ack,2 fetch) [1] expSet [0] expAfter
  localparam logic [21:0] VECS [0:NVEC-1] = '{
    {8'hFE, 8'h01, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0},
    {8'hFE, 8'h02, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0},
    {8'h7F, 8'hFF, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1},
    {8'h7F, 8'h80, 1'b1, 1'b0, 2'd1, 1'b1, 1'b1},
    {8'hEF, 8'h10, 1'b1, 1'b0, 2'd2, 1'b1, 1'b1},
    {8'hEF, 8'h10, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0},
    {8'h00, 8'h00, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0}
  };

  logic clk = 0;
  logic rstN = 0;
  logic [7:0] keyIn = 8'hFF;
  logic wrEn = 0;
  logic wrSel = 0;
  logic [7:0] wrData = 0;
  logic vectorFetch = 0;
  logic [7:0] pullupEn;
  logic keyFlag;
  logic irqReq;
  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic done = 0;

  keypad_irq u0 (.clk(clk), .rstN(rstN), .keyIn(keyIn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .vectorFetch(vectorFetch), .pullupEn(pullupEn),
    .keyFlag(keyFlag), .irqReq(irqReq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic sel, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 0; wrSel = 0; wrData = 0;
  endtask

  task automatic fetchPulse();
    @(negedge clk);
    vectorFetch = 1;
    @(negedge clk);
    vectorFetch = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG && !done) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 pullupEn", pullupEn, 8'h00);
    check("R1 keyFlag", {7'd0, keyFlag}, 8'd0);
    check("R1 irqReq", {7'd0, irqReq}, 8'd0);

    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] k, en;
      logic md, mk, eSet, eAft;
      logic [1:0] op;
      k = VECS[v][21:14]; en = VECS[v][13:6]; md = VECS[v][5]; mk = VECS[v][4];
      op = VECS[v][3:2]; eSet = VECS[v][1]; eAft = VECS[v][0];
      keyIn = 8'hFF;
      regWrite(1'b0, en);
      check("R2 pullupEn follows enable", pullupEn, en);
      regWrite(1'b1, {5'd0, 1'b1, md, mk});
      repeat (4) @(negedge clk);
      regWrite(1'b1, {5'd0, 1'b1, md, mk});
      keyIn = k;
      repeat (3) @(negedge clk);
      check("R3/R4 flag after keys", {7'd0, keyFlag}, {7'd0, eSet});
      check("R7 irq vs mask", {7'd0, irqReq}, {7'd0, eSet & ~mk});
      if (op == 2'd1) regWrite(1'b1, {5'd0, 1'b1, md, mk});
      else if (op == 2'd2) fetchPulse();
      check("R5/R6/R8 flag after clear request", {7'd0, keyFlag}, {7'd0, eAft});
      keyIn = 8'hFF;
      repeat (4) @(negedge clk);
      regWrite(1'b1, {5'd0, 1'b1, md, mk});
      check("R8 flag clears after release", {7'd0, keyFlag}, 8'd0);
    end

    // R3 exact latency
    regWrite(1'b1, 8'h04);
    regWrite(1'b0, 8'h01);
    keyIn = 8'hFE;
    repeat (2) @(negedge clk);
    check("R3 not set after two edges", {7'd0, keyFlag}, 8'd0);
    @(negedge clk);
    check("R3 set after third edge", {7'd0, keyFlag}, 8'd1);
    check("R7 irq unmasked equals flag", {7'd0, irqReq}, 8'd1);
    // R5 edge-mode ack clears even with key still low
    regWrite(1'b1, 8'h04);
    check("R5 ack clears while low in edge mode", {7'd0, keyFlag}, 8'd0);
    keyIn = 8'hFF;
    repeat (4) @(negedge clk);

    // R9 enabling a pin already low
    regWrite(1'b0, 8'h00);
    keyIn = 8'hF7;
    repeat (4) @(negedge clk);
    check("R4 disabled low pin ignored", {7'd0, keyFlag}, 8'd0);
    regWrite(1'b0, 8'h08);
    repeat (3) @(negedge clk);
    check("R9 enable of low pin sets flag", {7'd0, keyFlag}, 8'd1);
    check("R2 pullup bit 3", pullupEn, 8'h08);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule